// File: doc/BRIEF.md
# Two-Core Way Quota Engine

This block sets, once per epoch, how many ways of every set in a shared last-level cache each of two cores may own. It watches three streams of miss pulses. One comes from the real cache, running the current split. The other two come from shadow tag directories. One of those models the split with one way moved to core 1. The other models the split with one way moved to core 0. At each epoch boundary the engine adopts the split that missed least and presents it as a pair of registered way counts.

The quota only states a target. It moves no lines. The cache controller changes ownership of a way later, one line at a time, when a miss by an under-quota core finds a way held by the other core. An epoch ends on an external tick, or after a parameterised number of cache accesses. The miss history decays by half at each boundary, so it is not discarded. Neither core is ever left below a floor of ways.

Top module: `way_partition_engine`

## Requirements
- R1: During and after reset, `quota0_o` and `quota1_o` each equal WAYS/2 (8 for the default of 16 ways). In every cycle, `quota0_o + quota1_o` equals WAYS.
- R2: Three saturating counters hold the misses of the current epoch. Each cycle with `miss_cur_i`, `miss_to1_i` or `miss_to0_i` high adds one to the matching counter. `miss_to1_i` belongs to the split with core 0 at one way fewer. `miss_to0_i` belongs to the split with core 0 at one way more.
- R3: At an epoch boundary, the next `quota0_o` is the core-0 way count of the candidate split whose counter is lowest. The counts compared are those held before the boundary cycle's own pulses.
- R4: When counters tie, the current split wins over both shifts. Between the two shifts, the shift toward core 0 wins.
- R5: At an epoch boundary each counter becomes half its value, rounded down, plus that cycle's miss pulse. It does not become zero.
- R6: A shifted split that would leave either core with fewer than MIN_WAYS ways (default 2) takes no part in the comparison. Neither quota output ever goes below MIN_WAYS.
- R7: A counter at its maximum, 2^CNT_W-1, stays there when more misses arrive. It does not wrap to a small value.
- R8: An epoch boundary occurs in a cycle with `epoch_tick_i` high. It also occurs in the cycle that carries the EPOCH_LEN-th `access_i` pulse since the last boundary. Every boundary restarts the access count.
- R9: The quota outputs change only on the clock edge that closes a boundary cycle. Each change moves one way between the cores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| access_i | input | 1 | One pulse per cache access, used for epoch length |
| epoch_tick_i | input | 1 | Forces an epoch boundary this cycle |
| miss_cur_i | input | 1 | Miss in the real cache (current split) |
| miss_to1_i | input | 1 | Miss in the shadow directory with core 0 at one way fewer |
| miss_to0_i | input | 1 | Miss in the shadow directory with core 0 at one way more |
| quota0_o | output | $clog2(WAYS+1) | Ways per set that core 0 may own |
| quota1_o | output | $clog2(WAYS+1) | Ways per set that core 1 may own |

## Verification
The checker relies on the miss inputs being single-cycle events, at most one per source per clock. It also relies on the shadow pulses meaning the splits one way either side of the current quota. It does not rely on any fixed relation between ticks and accesses. The stimulus drives each input as an independent per-cycle bit with a phase-specific probability. The phases push the quota into both floors. They also hold the miss inputs high long enough to saturate the counters, produce exact ties, and mix external ticks with access-counted epochs.

// File: rtl/wpe_pkg.sv
package wpe_pkg;

   typedef enum logic [1:0] {
      PICK_KEEP = 2'd0,
      PICK_UP   = 2'd1,
      PICK_DOWN = 2'd2
   } pick_e;

endpackage

// File: rtl/wpe_miss_counter.sv
module wpe_miss_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             halve_i,
   input  logic             miss_i,
   output logic [CNT_W-1:0] cnt_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base;
   logic [CNT_W:0]   sum;

   always_comb begin
      base = halve_i ? (cnt_q >> 1) : cnt_q;
      sum  = {1'b0, base} + {{CNT_W{1'b0}}, miss_i};
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       cnt_q <= '0;
      else if (sum[CNT_W]) cnt_q <= '1;
      else               cnt_q <= sum[CNT_W-1:0];
   end

   assign cnt_o = cnt_q;

endmodule

// File: rtl/wpe_epoch_timer.sv
module wpe_epoch_timer #(
   parameter int EPOCH_LEN = 64
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic access_i,
   input  logic tick_i,
   output logic epoch_end_o
);

   generate
      if (EPOCH_LEN == 0) begin : g_tick_only
         assign epoch_end_o = tick_i;
      end else begin : g_access_count
         localparam int AW = (EPOCH_LEN > 1) ? $clog2(EPOCH_LEN) : 1;
         localparam logic [AW-1:0] LAST = AW'(EPOCH_LEN - 1);
         logic [AW-1:0] acc_q;
         logic          full;

         assign full        = access_i && (acc_q == LAST);
         assign epoch_end_o = tick_i || full;

         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)          acc_q <= '0;
            else if (epoch_end_o) acc_q <= '0;
            else if (access_i)    acc_q <= acc_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/wpe_split_select.sv
module wpe_split_select
   import wpe_pkg::*;
#(
   parameter int WAYS     = 16,
   parameter int MIN_WAYS = 2,
   parameter int CNT_W    = 8,
   parameter int QW       = $clog2(WAYS + 1)
) (
   input  logic [QW-1:0]    quota0_i,
   input  logic [CNT_W-1:0] cnt_keep_i,
   input  logic [CNT_W-1:0] cnt_up_i,
   input  logic [CNT_W-1:0] cnt_down_i,
   output logic [QW-1:0]    quota0_o
);

   localparam logic [QW-1:0] HI_LIMIT = QW'(WAYS - MIN_WAYS);
   localparam logic [QW-1:0] LO_LIMIT = QW'(MIN_WAYS);

   logic             up_ok;
   logic             down_ok;
   logic [CNT_W-1:0] best_val;
   pick_e            pick;

   assign up_ok   = quota0_i < HI_LIMIT;
   assign down_ok = quota0_i > LO_LIMIT;

   always_comb begin
      pick     = PICK_KEEP;
      best_val = cnt_keep_i;
      if (up_ok && (cnt_up_i < best_val)) begin
         pick     = PICK_UP;
         best_val = cnt_up_i;
      end
      if (down_ok && (cnt_down_i < best_val)) begin
         pick     = PICK_DOWN;
         best_val = cnt_down_i;
      end
      unique case (pick)
         PICK_UP:   quota0_o = quota0_i + 1'b1;
         PICK_DOWN: quota0_o = quota0_i - 1'b1;
         default:   quota0_o = quota0_i;
      endcase
   end

endmodule

// File: rtl/way_partition_engine.sv
module way_partition_engine #(
   parameter int WAYS      = 16,
   parameter int MIN_WAYS  = 2,
   parameter int CNT_W     = 8,
   parameter int EPOCH_LEN = 64,
   parameter int QW        = $clog2(WAYS + 1)
) (
   input  logic          clk_i,
   input  logic          rst_ni,
   input  logic          access_i,
   input  logic          epoch_tick_i,
   input  logic          miss_cur_i,
   input  logic          miss_to1_i,
   input  logic          miss_to0_i,
   output logic [QW-1:0] quota0_o,
   output logic [QW-1:0] quota1_o
);

   localparam int NSRC = 3;
   localparam logic [QW-1:0] HALF   = QW'(WAYS / 2);
   localparam logic [QW-1:0] WAYS_Q = QW'(WAYS);

   initial begin
      assert (WAYS % 2 == 0) else $error("WAYS must be even");
      assert (MIN_WAYS >= 1 && 2 * MIN_WAYS <= WAYS) else $error("MIN_WAYS out of range");
      assert (CNT_W >= 2) else $error("CNT_W too small");
      assert (EPOCH_LEN >= 0) else $error("EPOCH_LEN negative");
   end

   logic             epoch_end;
   logic [NSRC-1:0]  miss_vec;
   logic [CNT_W-1:0] cnt_q [NSRC];
   logic [QW-1:0]    q0_q, q1_q, q0_nxt;

   // index 0: current split, 1: core 0 one way more, 2: core 0 one way fewer
   assign miss_vec = {miss_to1_i, miss_to0_i, miss_cur_i};

   wpe_epoch_timer #(.EPOCH_LEN(EPOCH_LEN)) timer_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .access_i    (access_i),
      .tick_i      (epoch_tick_i),
      .epoch_end_o (epoch_end)
   );

   generate
      for (genvar s = 0; s < NSRC; s++) begin : g_cnt
         wpe_miss_counter #(.CNT_W(CNT_W)) cnt_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .halve_i (epoch_end),
            .miss_i  (miss_vec[s]),
            .cnt_o   (cnt_q[s])
         );
      end
   endgenerate

   wpe_split_select #(
      .WAYS(WAYS), .MIN_WAYS(MIN_WAYS), .CNT_W(CNT_W), .QW(QW)
   ) sel_i (
      .quota0_i   (q0_q),
      .cnt_keep_i (cnt_q[0]),
      .cnt_up_i   (cnt_q[1]),
      .cnt_down_i (cnt_q[2]),
      .quota0_o   (q0_nxt)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         q0_q <= HALF;
         q1_q <= HALF;
      end else if (epoch_end) begin
         q0_q <= q0_nxt;
         q1_q <= WAYS_Q - q0_nxt;
      end
   end

   assign quota0_o = q0_q;
   assign quota1_o = q1_q;

endmodule

module wpe_chk #(
   parameter int WAYS     = 16,
   parameter int MIN_WAYS = 2,
   parameter int CNT_W    = 8,
   parameter int QW       = $clog2(WAYS + 1)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             epoch_end,
   input logic             miss_cur_i,
   input logic [CNT_W-1:0] cnt_cur,
   input logic [QW-1:0]    quota0_o,
   input logic [QW-1:0]    quota1_o
);

   // R1
   quota_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(quota0_o) + 32'(quota1_o)) == WAYS);

   // R6
   quota_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (32'(quota0_o) >= MIN_WAYS) && (32'(quota1_o) >= MIN_WAYS));

   // R9
   quota_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !epoch_end |=> $stable(quota0_o));

   // R9
   quota_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      epoch_end |=> ((quota0_o == $past(quota0_o)) ||
                     (quota0_o == $past(quota0_o) + 1'b1) ||
                     (quota0_o == $past(quota0_o) - 1'b1)));

   // R7
   no_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt_cur == '1) && miss_cur_i && !epoch_end |=> (cnt_cur == '1));

   // R5
   halve_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      epoch_end && !miss_cur_i |=> (cnt_cur == ($past(cnt_cur) >> 1)));

endmodule

bind way_partition_engine wpe_chk #(
   .WAYS(WAYS), .MIN_WAYS(MIN_WAYS), .CNT_W(CNT_W), .QW(QW)
) chk_i (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .epoch_end  (epoch_end),
   .miss_cur_i (miss_cur_i),
   .cnt_cur    (cnt_q[0]),
   .quota0_o   (quota0_o),
   .quota1_o   (quota1_o)
);

// File: tb/way_partition_engine_tb.sv
module way_partition_engine_tb_top;

   localparam int WAYS      = 16;
   localparam int MIN_WAYS  = 2;
   localparam int CNT_W     = 6;
   localparam int EPOCH_LEN = 12;
   localparam int QW        = $clog2(WAYS + 1);
   localparam int CMAX      = (1 << CNT_W) - 1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic access = 1'b0, tick = 1'b0;
   logic m_cur = 1'b0, m_to1 = 1'b0, m_to0 = 1'b0;
   logic [QW-1:0] q0, q1;

   int n_tests = 0;
   int n_fail  = 0;
   string tag  = "R1";

   always #2.5 clk = ~clk;

   way_partition_engine #(
      .WAYS(WAYS), .MIN_WAYS(MIN_WAYS), .CNT_W(CNT_W), .EPOCH_LEN(EPOCH_LEN)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .access_i(access), .epoch_tick_i(tick),
      .miss_cur_i(m_cur), .miss_to1_i(m_to1), .miss_to0_i(m_to0),
      .quota0_o(q0), .quota1_o(q1)
   );

   // behavioural reference
   int ref_q0 = WAYS / 2;
   int ref_c[3] = '{0, 0, 0};   // 0 current, 1 core0 fewer, 2 core0 more
   int ref_acc = 0;
   int n_bnd = 0;
   int n_move = 0;

   function automatic int sat(input int v);
      return (v > CMAX) ? CMAX : v;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         ref_q0 = WAYS / 2;
         ref_c = '{0, 0, 0};
         ref_acc = 0;
      end else begin
         bit bnd;
         int m[3];
         m[0] = int'(m_cur); m[1] = int'(m_to1); m[2] = int'(m_to0);
         bnd = tick || (access && ref_acc == EPOCH_LEN - 1);
         if (bnd) ref_acc = 0;
         else if (access) ref_acc++;
         if (bnd) begin
            int best, val, old;
            old = ref_q0;
            best = ref_q0; val = ref_c[0];
            if (ref_q0 + 1 <= WAYS - MIN_WAYS && ref_c[2] < val) begin
               best = ref_q0 + 1; val = ref_c[2];
            end
            if (ref_q0 - 1 >= MIN_WAYS && ref_c[1] < val) begin
               best = ref_q0 - 1; val = ref_c[1];
            end
            ref_q0 = best;
            n_bnd++;
            if (best != old) n_move++;
            for (int i = 0; i < 3; i++) ref_c[i] = sat(ref_c[i] / 2 + m[i]);
         end else begin
            for (int i = 0; i < 3; i++) ref_c[i] = sat(ref_c[i] + m[i]);
         end
      end
   end

   task automatic check(input string req, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // compare on every falling edge
   always @(negedge clk) begin
      check(tag, int'(q0), ref_q0);
      check(tag, int'(q1), WAYS - ref_q0);
   end

   function automatic logic pr(input int pct);
      return ($urandom_range(99, 0) < pct);
   endfunction

   task automatic run(input int cycles, input int p_acc, input int p_tick,
                      input int p_cur, input int p_to1, input int p_to0);
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         #0.5;
         access = pr(p_acc); tick = pr(p_tick);
         m_cur = pr(p_cur); m_to1 = pr(p_to1); m_to0 = pr(p_to0);
      end
      @(negedge clk);
      #0.5;
      access = 0; tick = 0; m_cur = 0; m_to1 = 0; m_to0 = 0;
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      // R1: reset values held across several edges
      tag = "R1";
      repeat (4) @(negedge clk);
      check("R1", int'(q0), WAYS / 2);
      check("R1", int'(q1), WAYS / 2);
      #0.5 rst_n = 1'b1;
      run(20, 0, 0, 0, 0, 0);
      // R2 R3: core-0-fewer split misses least, quota drifts down to floor (R6)
      tag = "R3";
      run(300, 20, 5, 60, 5, 60);
      tag = "R6";
      run(200, 30, 5, 60, 0, 70);
      check("R6", int'(q0), MIN_WAYS);
      // R2: core-0-more split wins, drifts up to upper floor
      tag = "R2";
      run(600, 30, 5, 50, 70, 5);
      check("R6", int'(q1), MIN_WAYS);
      // R4: ties of zero counts keep current split
      tag = "R4";
      run(100, 0, 0, 0, 0, 0);
      run(40, 0, 30, 0, 0, 0);
      check("R4", int'(q0), WAYS - MIN_WAYS);
      // R4: equal shifted counts, current high: shift toward core 0 preferred
      run(300, 20, 5, 80, 30, 30);
      // R7: saturate all counters, then boundary with all at maximum
      tag = "R7";
      run(200, 0, 0, 100, 100, 100);
      run(30, 0, 20, 0, 0, 0);
      run(200, 0, 0, 100, 40, 100);
      run(30, 0, 20, 0, 0, 0);
      // R5: history carries over the halving
      tag = "R5";
      run(400, 25, 3, 40, 20, 50);
      // R8: access-counted epochs only
      tag = "R8";
      run(600, 60, 0, 40, 60, 20);
      // R9: random mix, quota moves only after boundaries
      tag = "R9";
      run(2000, 50, 4, 40, 40, 40);
      check("R9", int'(n_bnd > 50 && n_move > 10), 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule